// File: doc/BRIEF.md
# Dual-Buffer Ethernet Transmit Controller

This block is the transmit half of a small memory-mapped Ethernet MAC. A host prepares frames in two independent buffer RAMs and hands them to a single command engine. The host writes frame bytes into a buffer and sets that buffer's length register. It then writes the buffer's control word. One control word carries two commands. With the start bit alone, the first `length` bytes of the buffer leave as a byte stream with valid, ready and last signals. With the start and program bits together, the first six bytes of the buffer are copied into the station address register and no frame leaves.

The start and program bits read back as 1 while the command is pending or running. They clear by themselves when the command finishes. Completion can raise a one-cycle interrupt pulse, gated by a per-buffer enable bit and by one global enable bit. The host usually alternates between the buffers: it fills one while the engine drains the other. A start on the second buffer waits until the running command ends.

The engine runs through five named states:
- ST_IDLE picks a pending buffer. It moves to ST_MAC_LO for a program command, to ST_DONE for a zero length, or to ST_STREAM otherwise.
- ST_STREAM sends one byte per accepted beat. It moves to ST_DONE after the last byte.
- ST_MAC_LO loads address bytes 0..3 and moves to ST_MAC_HI.
- ST_MAC_HI loads bytes 4..5 and moves to ST_DONE.
- ST_DONE clears the busy bits, may pulse the interrupt, and returns to ST_IDLE.

Top module: `ethtx_dualbuf`

## Requirements
- R1: After reset, both control words, both length registers and the global enable read 0, `station_mac` is 0, and `tx_tvalid` and `irq_pulse` are low.
- R2: The host uses 32-bit word accesses only. The byte offset is `bus_addr` times 4, and bit 11 selects the buffer (0x000 or 0x800).
  - Word offsets 0x000..0x7F0 of each buffer are frame RAM, which reads back what was written.
  - 0x7F4 is that buffer's length, held in 11 bits. Upper bits read 0.
  - 0x7F8 is the global enable register. Only bit 31 is held, and it exists only in buffer 0.
  - 0x7FC is the control word.
  - Offset 0xFF8 reads 0, and writes to it have no effect.
- R3: A control write with bit 0 = 1 and bit 1 = 0 sends the first `length` bytes of that buffer, lowest address first. Within each RAM word, bits [7:0] go out first and bits [31:24] go out last. `tx_tlast` is high only on the final byte.
- R4: While `tx_tvalid` is high and `tx_tready` is low, `tx_tdata` and `tx_tlast` hold their values and `tx_tvalid` stays high.
- R5: A control write with bits 0 and 1 both set loads `station_mac[8*i+7:8*i]` with byte i of the buffer, for i = 0..5. No byte is sent.
- R6: The control word reads bit 0 = 1 while its command is pending or running. It reads bit 1 = 1 during a program command. Both read 0 after completion. Written bits 31..2 other than bit 1 are kept.
- R7: A control write to a buffer whose bit 0 reads 1 is ignored completely.
- R8: A start with length 0 completes without any `tx_tvalid` beat.
- R9: Each completed command gives exactly one one-cycle `irq_pulse`, but only when that buffer's control bit 3 is set and global enable bit 31 is set. Otherwise no pulse is given.
- R10: A start written to the other buffer while a frame is streaming is served right after the running command completes. No byte of either frame is lost, and each frame ends with its own `tx_tlast`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_wr_en | input | 1 | Word write strobe |
| bus_addr | input | 10 | Word address (byte offset bits 11..2) |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| tx_tdata | output | 8 | Outgoing frame byte |
| tx_tvalid | output | 1 | Byte valid |
| tx_tready | input | 1 | Sink accepts byte |
| tx_tlast | output | 1 | Final byte of the frame |
| station_mac | output | 48 | Station address register |
| irq_pulse | output | 1 | One-cycle completion interrupt |

## Verification
Two functions can meet in the same stretch of cycles: the engine streaming buffer 0 against a stalled sink, and a host command write to buffer 1 that must queue behind it. The bench starts buffer 0 with the sink held off and then issues the buffer 1 start. It releases the sink and judges the single byte stream: buffer 0's bytes must appear in order, then buffer 1's, each ending with its own last flag, with one interrupt per buffer. A further run writes a program command into a busy buffer. It then checks at the ports that the station address and the control readback are unchanged.

// File: rtl/ethtx_pkg.sv
package ethtx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_STREAM,
        ST_MAC_LO,
        ST_MAC_HI,
        ST_DONE
    } eng_state_t;

    localparam int CTRL_START = 0;
    localparam int CTRL_PROG  = 1;
    localparam int CTRL_IE    = 3;
    localparam int GIE_BIT    = 31;

endpackage

// File: rtl/ethtx_buf_ram.sv
module ethtx_buf_ram #(
    parameter int WORDS = 509,
    parameter int IDX_W = 9
) (
    input  logic             clk,
    input  logic             we,
    input  logic [IDX_W-1:0] w_idx,
    input  logic [31:0]      w_data,
    input  logic [IDX_W-1:0] a_idx,
    output logic [31:0]      a_data,
    input  logic [IDX_W-1:0] b_idx,
    output logic [31:0]      b_data
);
    logic [31:0] mem [WORDS];

    always_ff @(posedge clk) begin
        if (we && (w_idx < IDX_W'(WORDS))) begin
            mem[w_idx] <= w_data;
        end
    end

    assign a_data = (a_idx < IDX_W'(WORDS)) ? mem[a_idx] : '0;
    assign b_data = (b_idx < IDX_W'(WORDS)) ? mem[b_idx] : '0;
endmodule

// File: rtl/ethtx_engine.sv
module ethtx_engine
    import ethtx_pkg::*;
#(
    parameter int IDX_W = 9,
    parameter int LEN_W = 11
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [1:0]            busy_i,
    input  logic [1:0]            prog_i,
    input  logic [1:0][LEN_W-1:0] len_i,
    input  logic [1:0]            ie_i,
    input  logic                  gie_i,
    output logic                  rd_buf_o,
    output logic [IDX_W-1:0]      rd_idx_o,
    input  logic [31:0]           rd_word_i,
    output logic [7:0]            tx_tdata,
    output logic                  tx_tvalid,
    input  logic                  tx_tready,
    output logic                  tx_tlast,
    output logic [47:0]           mac_o,
    output logic                  irq_o,
    output logic                  done_o,
    output logic                  done_buf_o
);
    eng_state_t       state_q, state_d;
    logic             cur_q;
    logic [LEN_W-1:0] cnt_q;
    logic [47:0]      mac_q;

    logic             pick;
    logic             last_beat;

    assign pick      = busy_i[0] ? 1'b0 : 1'b1;
    assign last_beat = (cnt_q == len_i[cur_q] - LEN_W'(1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (busy_i != 2'b00) begin
                    if (prog_i[pick])                 state_d = ST_MAC_LO;
                    else if (len_i[pick] == '0)       state_d = ST_DONE;
                    else                              state_d = ST_STREAM;
                end
            end
            ST_STREAM: if (tx_tready && last_beat)    state_d = ST_DONE;
            ST_MAC_LO:                                state_d = ST_MAC_HI;
            ST_MAC_HI:                                state_d = ST_DONE;
            ST_DONE:                                  state_d = ST_IDLE;
            default:                                  state_d = ST_IDLE;
        endcase
    end

    // state register and datapath registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            cur_q   <= 1'b0;
            cnt_q   <= '0;
            mac_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && busy_i != 2'b00) begin
                cur_q <= pick;
                cnt_q <= '0;
            end
            if (state_q == ST_STREAM && tx_tready) cnt_q <= cnt_q + LEN_W'(1);
            if (state_q == ST_MAC_LO) mac_q[31:0]  <= rd_word_i;
            if (state_q == ST_MAC_HI) mac_q[47:32] <= rd_word_i[15:0];
        end
    end

    // outputs
    always_comb begin
        rd_buf_o   = cur_q;
        rd_idx_o   = '0;
        tx_tvalid  = 1'b0;
        tx_tlast   = 1'b0;
        tx_tdata   = rd_word_i[{cnt_q[1:0], 3'b000} +: 8];
        irq_o      = 1'b0;
        done_o     = 1'b0;
        done_buf_o = cur_q;
        unique case (state_q)
            ST_STREAM: begin
                rd_idx_o  = IDX_W'(cnt_q[LEN_W-1:2]);
                tx_tvalid = 1'b1;
                tx_tlast  = last_beat;
            end
            ST_MAC_LO: rd_idx_o = IDX_W'(0);
            ST_MAC_HI: rd_idx_o = IDX_W'(1);
            ST_DONE: begin
                done_o = 1'b1;
                irq_o  = ie_i[cur_q] && gie_i;
            end
            default: ;
        endcase
    end

    assign mac_o = mac_q;

    // R4: stalled beat holds
    a_r4_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tvalid && !tx_tready |=> tx_tvalid && $stable(tx_tdata) && $stable(tx_tlast));

    // R9: interrupt is a single-cycle pulse
    a_r9_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |=> !irq_o);

    // R5: station address moves only during a load command
    a_r5_mac_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(state_q == ST_MAC_LO || state_q == ST_MAC_HI) |=> $stable(mac_o));

    // R3: bytes only leave for a buffer that the host marked busy
    a_r3_valid_busy: assert property (@(posedge clk) disable iff (!rst_n)
        tx_tvalid |-> busy_i[cur_q] && !prog_i[cur_q]);
endmodule

// File: rtl/ethtx_dualbuf.sv
module ethtx_dualbuf
    import ethtx_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr_en,
    input  logic [ADDR_W-1:2] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic [7:0]        tx_tdata,
    output logic              tx_tvalid,
    input  logic              tx_tready,
    output logic              tx_tlast,
    output logic [47:0]       station_mac,
    output logic              irq_pulse
);
    localparam int IDX_W      = ADDR_W - 3;
    localparam int SPAN_WORDS = 2 ** IDX_W;
    localparam int RAM_WORDS  = SPAN_WORDS - 3;
    localparam int LEN_IDX    = SPAN_WORDS - 3;
    localparam int GIE_IDX    = SPAN_WORDS - 2;
    localparam int CTRL_IDX   = SPAN_WORDS - 1;
    localparam int LEN_W      = IDX_W + 2;

    logic             buf_sel;
    logic [IDX_W-1:0] widx;
    logic             is_ram;

    assign buf_sel = bus_addr[ADDR_W-1];
    assign widx    = bus_addr[ADDR_W-2:2];
    assign is_ram  = widx < IDX_W'(RAM_WORDS);

    logic [LEN_W-1:0]      len_q  [2];
    logic [31:2]           keep_q [2];
    logic [1:0]            busy_q, prog_q;
    logic                  gie_q;
    logic [1:0][LEN_W-1:0] len_pk;
    logic [1:0]            ie_vec;
    logic [31:0]           host_word [2];
    logic [31:0]           eng_word  [2];

    logic             eng_buf;
    logic [IDX_W-1:0] eng_idx;
    logic             done, done_buf;

    for (genvar b = 0; b < 2; b++) begin : g_buf
        logic sel_here;
        assign sel_here = (buf_sel == 1'(b));

        ethtx_buf_ram #(.WORDS(RAM_WORDS), .IDX_W(IDX_W)) u_ram (
            .clk    (clk),
            .we     (bus_wr_en && sel_here && is_ram),
            .w_idx  (widx),
            .w_data (bus_wdata),
            .a_idx  (widx),
            .a_data (host_word[b]),
            .b_idx  (eng_idx),
            .b_data (eng_word[b])
        );

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                len_q[b]  <= '0;
                keep_q[b] <= '0;
                busy_q[b] <= 1'b0;
                prog_q[b] <= 1'b0;
            end else begin
                if (bus_wr_en && sel_here && widx == IDX_W'(LEN_IDX))
                    len_q[b] <= bus_wdata[LEN_W-1:0];
                if (bus_wr_en && sel_here && widx == IDX_W'(CTRL_IDX) && !busy_q[b]) begin
                    keep_q[b] <= {bus_wdata[31:2]};
                    keep_q[b][CTRL_PROG] <= 1'b0;
                    if (bus_wdata[CTRL_START]) begin
                        busy_q[b] <= 1'b1;
                        prog_q[b] <= bus_wdata[CTRL_PROG];
                    end
                end else if (done && done_buf == 1'(b)) begin
                    busy_q[b] <= 1'b0;
                    prog_q[b] <= 1'b0;
                end
            end
        end

        assign len_pk[b] = len_q[b];
        assign ie_vec[b] = keep_q[b][CTRL_IE];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) gie_q <= 1'b0;
        else if (bus_wr_en && !buf_sel && widx == IDX_W'(GIE_IDX)) gie_q <= bus_wdata[GIE_BIT];
    end

    always_comb begin
        bus_rdata = '0;
        if (is_ram)
            bus_rdata = host_word[buf_sel];
        else if (widx == IDX_W'(LEN_IDX))
            bus_rdata = 32'(len_q[buf_sel]);
        else if (widx == IDX_W'(GIE_IDX) && !buf_sel)
            bus_rdata = {gie_q, 31'b0};
        else if (widx == IDX_W'(CTRL_IDX))
            bus_rdata = {keep_q[buf_sel][31:2], prog_q[buf_sel], busy_q[buf_sel]};
    end

    ethtx_engine #(.IDX_W(IDX_W), .LEN_W(LEN_W)) u_engine (
        .clk        (clk),
        .rst_n      (rst_n),
        .busy_i     (busy_q),
        .prog_i     (prog_q),
        .len_i      (len_pk),
        .ie_i       (ie_vec),
        .gie_i      (gie_q),
        .rd_buf_o   (eng_buf),
        .rd_idx_o   (eng_idx),
        .rd_word_i  (eng_word[eng_buf]),
        .tx_tdata   (tx_tdata),
        .tx_tvalid  (tx_tvalid),
        .tx_tready  (tx_tready),
        .tx_tlast   (tx_tlast),
        .mac_o      (station_mac),
        .irq_o      (irq_pulse),
        .done_o     (done),
        .done_buf_o (done_buf)
    );

    // R6: busy bit of buffer 0 only drops on its own completion
    a_r6_clear_buf0: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q[0]) |-> $past(done && done_buf == 1'b0));

    // R6: busy bit of buffer 1 only drops on its own completion
    a_r6_clear_buf1: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_q[1]) |-> $past(done && done_buf == 1'b1));

    // R9: no pulse without the global enable
    a_r9_gie_gate: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> gie_q);

    // R7: a busy buffer keeps its program bit across host writes
    a_r7_prog_locked: assert property (@(posedge clk) disable iff (!rst_n)
        busy_q[0] && !(done && done_buf == 1'b0) |=> $stable(prog_q[0]));
endmodule

// File: tb/ethtx_dualbuf_test.sv
module ethtx_dualbuf_test;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_wr_en = 1'b0;
    logic [11:2] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic [7:0]  tx_tdata;
    logic        tx_tvalid;
    logic        tx_tready = 1'b1;
    logic        tx_tlast;
    logic [47:0] station_mac;
    logic        irq_pulse;

    always #2.5 clk = ~clk;

    ethtx_dualbuf uut (
        .clk(clk), .rst_n(rst_n), .bus_wr_en(bus_wr_en), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .tx_tdata(tx_tdata),
        .tx_tvalid(tx_tvalid), .tx_tready(tx_tready), .tx_tlast(tx_tlast),
        .station_mac(station_mac), .irq_pulse(irq_pulse)
    );

    localparam logic [11:0] LEN0 = 12'h7F4, GIE = 12'h7F8, CTRL0 = 12'h7FC;
    localparam logic [11:0] LEN1 = 12'hFF4, CTRL1 = 12'hFFC;

    int checks = 0;
    int fails  = 0;
    int rx_count = 0;
    int irq_count = 0;
    logic [7:0] rx_data [0:255];
    logic       rx_last [0:255];
    logic       stall_mode = 1'b0;
    logic       prev_stall = 1'b0;
    logic [7:0] prev_data;
    logic       prev_last;
    int         cyc = 0;

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // collector and stall checker, sampled at the falling edge
    always @(negedge clk) begin
        if (rst_n) begin
            if (prev_stall)
                check(tx_tvalid && tx_tdata == prev_data && tx_tlast == prev_last,
                      "R4 stalled beat changed", {tx_tvalid, tx_tlast, tx_tdata},
                      {1'b1, prev_last, prev_data});
            prev_stall = tx_tvalid && !tx_tready;
            prev_data  = tx_tdata;
            prev_last  = tx_tlast;
            if (tx_tvalid && tx_tready && rx_count < 256) begin
                rx_data[rx_count] = tx_tdata;
                rx_last[rx_count] = tx_tlast;
                rx_count++;
            end
            if (irq_pulse) irq_count++;
        end
    end

    always @(posedge clk) begin
        cyc++;
        #1;
        if (stall_mode) tx_tready = cyc[0] ^ cyc[2];
    end

    function automatic logic [7:0] pat(input logic [7:0] seed, input int i);
        return seed + 8'(i * 7);
    endfunction

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a[11:2]; bus_wdata = d; bus_wr_en = 1'b1;
        @(posedge clk); #1;
        bus_wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_addr = a[11:2];
        #1;
        d = bus_rdata;
    endtask

    task automatic fill(input logic [11:0] base, input int n, input logic [7:0] seed);
        for (int w = 0; w < (n + 3) / 4; w++)
            wr(base + 12'(4 * w), {pat(seed, 4*w+3), pat(seed, 4*w+2), pat(seed, 4*w+1), pat(seed, 4*w)});
    endtask

    task automatic wait_idle();
        logic [31:0] c0, c1;
        for (int k = 0; k < 2000; k++) begin
            rd(CTRL0, c0);
            rd(CTRL1, c1);
            if (!c0[0] && !c1[0]) break;
        end
        repeat (3) @(posedge clk);
    endtask

    task automatic clear_rx();
        rx_count = 0;
        irq_count = 0;
    endtask

    task automatic check_frame(input string tag, input int start, input int n, input logic [7:0] seed);
        for (int i = 0; i < n; i++) begin
            check(rx_data[start+i] == pat(seed, i), tag, rx_data[start+i], pat(seed, i));
            check(rx_last[start+i] == (i == n - 1), tag, rx_last[start+i], (i == n - 1));
        end
    endtask

    task automatic t_reset();
        logic [31:0] d;
        rd(CTRL0, d); check(d == 0, "R1 ctrl0", d, 0);
        rd(CTRL1, d); check(d == 0, "R1 ctrl1", d, 0);
        rd(LEN0, d);  check(d == 0, "R1 len0", d, 0);
        rd(LEN1, d);  check(d == 0, "R1 len1", d, 0);
        rd(GIE, d);   check(d == 0, "R1 gie", d, 0);
        check(station_mac == 0, "R1 mac", station_mac, 0);
        check(!tx_tvalid && !irq_pulse, "R1 outputs", {tx_tvalid, irq_pulse}, 0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        wr(12'h004, 32'hA1B2C3D4);
        wr(12'h804, 32'h0F1E2D3C);
        rd(12'h004, d); check(d == 32'hA1B2C3D4, "R2 buf0 ram", d, 32'hA1B2C3D4);
        rd(12'h804, d); check(d == 32'h0F1E2D3C, "R2 buf1 ram", d, 32'h0F1E2D3C);
        wr(LEN0, 32'hFFFF_F805);
        rd(LEN0, d); check(d == 32'h0000_0005, "R2 len width", d, 32'h5);
        wr(GIE, 32'hFFFF_FFFF);
        rd(GIE, d); check(d == 32'h8000_0000, "R2 gie bit", d, 32'h8000_0000);
        wr(12'hFF8, 32'h1234_5678);
        rd(12'hFF8, d); check(d == 0, "R2 unmapped", d, 0);
        wr(GIE, 0);
    endtask

    task automatic t_send();
        logic [31:0] d;
        clear_rx();
        fill(12'h000, 7, 8'h10);
        wr(LEN0, 7);
        wr(GIE, 32'h8000_0000);
        wr(CTRL0, 32'h0000_0009);
        wait_idle();
        check(rx_count == 7, "R3 byte count", rx_count, 7);
        check_frame("R3 frame bytes", 0, 7, 8'h10);
        check(irq_count == 1, "R9 irq on send", irq_count, 1);
        rd(CTRL0, d); check(d == 32'h8, "R6 ctrl after send", d, 32'h8);
    endtask

    task automatic t_stall();
        clear_rx();
        fill(12'h800, 10, 8'h40);
        wr(LEN1, 10);
        stall_mode = 1'b1;
        wr(CTRL1, 32'h0000_0001);
        wait_idle();
        stall_mode = 1'b0;
        @(posedge clk); #1; tx_tready = 1'b1;
        check(rx_count == 10, "R4 count under stall", rx_count, 10);
        check_frame("R4 bytes under stall", 0, 10, 8'h40);
        check(irq_count == 0, "R9 no irq without ie", irq_count, 0);
    endtask

    task automatic t_gie_off();
        clear_rx();
        wr(GIE, 0);
        wr(LEN0, 2);
        wr(CTRL0, 32'h0000_0009);
        wait_idle();
        check(rx_count == 2, "R3 two bytes", rx_count, 2);
        check(irq_count == 0, "R9 gie off", irq_count, 0);
    endtask

    task automatic t_mac();
        logic [31:0] d;
        clear_rx();
        wr(12'h000, 32'h4433_2211);
        wr(12'h004, 32'hBEEF_6655);
        wr(CTRL0, 32'h0000_0003);
        rd(CTRL0, d); check(d == 32'h3, "R6 prog busy readback", d, 32'h3);
        wait_idle();
        check(station_mac == 48'h6655_4433_2211, "R5 mac value", station_mac, 48'h6655_4433_2211);
        check(rx_count == 0, "R5 no bytes", rx_count, 0);
        rd(CTRL0, d); check(d == 0, "R6 ctrl after load", d, 0);
    endtask

    task automatic t_busy();
        logic [31:0] d;
        clear_rx();
        @(posedge clk); #1; tx_tready = 1'b0;
        fill(12'h000, 20, 8'h80);
        wr(LEN0, 20);
        wr(CTRL0, 32'h0000_0001);
        rd(CTRL0, d); check(d == 32'h1, "R6 busy readback", d, 32'h1);
        wr(CTRL0, 32'h0000_000B);
        rd(CTRL0, d); check(d == 32'h1, "R7 write ignored", d, 32'h1);
        @(posedge clk); #1; tx_tready = 1'b1;
        wait_idle();
        check(station_mac == 48'h6655_4433_2211, "R7 mac unchanged", station_mac, 48'h6655_4433_2211);
        check(rx_count == 20, "R7 single frame", rx_count, 20);
        check_frame("R7 frame bytes", 0, 20, 8'h80);
        check(irq_count == 0, "R7 ie not taken", irq_count, 0);
    endtask

    task automatic t_len0();
        clear_rx();
        wr(GIE, 32'h8000_0000);
        wr(LEN0, 0);
        wr(CTRL0, 32'h0000_0009);
        wait_idle();
        check(rx_count == 0, "R8 no beats", rx_count, 0);
        check(irq_count == 1, "R8 completes", irq_count, 1);
    endtask

    task automatic t_queue();
        clear_rx();
        @(posedge clk); #1; tx_tready = 1'b0;
        fill(12'h000, 4, 8'h21);
        fill(12'h800, 3, 8'h90);
        wr(LEN0, 4);
        wr(LEN1, 3);
        wr(CTRL0, 32'h0000_0009);
        wr(CTRL1, 32'h0000_0009);
        @(posedge clk); #1; tx_tready = 1'b1;
        wait_idle();
        check(rx_count == 7, "R10 total bytes", rx_count, 7);
        check_frame("R10 first frame", 0, 4, 8'h21);
        check_frame("R10 second frame", 4, 3, 8'h90);
        check(irq_count == 2, "R10 two irqs", irq_count, 2);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (4) @(posedge clk);
        #1 rst_n = 1'b1;
        t_reset();
        t_map();
        t_send();
        t_stall();
        t_gie_off();
        t_mac();
        t_busy();
        t_len0();
        t_queue();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule